// File: doc/BRIEF.md
# Multi-Mode Pattern Bank Address Translator

This block turns a 13-bit pattern-table address from the picture unit into an address in a banked character memory. The 8 KB pattern space is cut into windows of 1, 2, 4 or 8 KB. A 3-bit layout code picks how the space is cut and which of eight 8-bit bank registers (slots 0 to 7), or a separate latch bank, serves each window. The chosen bank number is scaled to the window size, optionally halved, and joined to the in-window offset. The result is then folded into a power-of-two memory size given by an inverted size mask.

The register file, the latch drivers and any write protection sit outside the block. They present their current values on the ports. The translation is combinational. One output register holds the result, so an address presented in one cycle appears on `chr_addr` after the next rising clock edge.

Top module: `chr_bank_xlat`

## Requirements
- R1: While `rst` is high at a rising edge, `chr_addr` becomes 0 after that edge. After reset, `chr_addr` shows the translation of the inputs sampled at the previous rising edge.
- R2: In every layout, `chr_addr[9:0]` equals `pat_addr[9:0]`.
- R3: Layout 0 maps the whole 8 KB from slot 0 with its three low bits ignored: address = (slot0/8)·8192 + pat_addr.
- R4: Layout 1 maps both 4 KB halves from the latch bank, taken as a 4 KB page number: address = latch·4096 + pat_addr mod 4096.
- R5: Layout 2 uses 2 KB windows at 0x0000 (slot 0) and 0x0800 (slot 2), and 1 KB windows at 0x1000, 0x1400, 0x1800 and 0x1C00 from slots 4, 5, 6 and 7.
- R6: Layout 3 uses 1 KB windows from slots 4, 5, 6 and 7 at 0x0000 to 0x0C00, and 2 KB windows from slot 0 at 0x1000 and slot 2 at 0x1800.
- R7: Layout 4 uses two 4 KB windows: slot 0 for the lower half and slot 4 for the upper half.
- R8: Layout 5 uses 4 KB windows. The lower one comes from slot 1 when `latch_sel_lo` is 1 and from slot 0 otherwise. The upper one comes from slot 5 when `latch_sel_hi` is 1 and from slot 4 otherwise.
- R9: Layout 6 uses four 2 KB windows from slots 0, 2, 4 and 6, in ascending address order.
- R10: Layout 7 uses eight 1 KB windows from slots 0 through 7, in ascending address order.
- R11: With `halve` high, the bank number in window units (slot value divided by the window size in KB, or the latch value) is divided by two, rounding down, before it is scaled.
- R12: The result is ANDed with {~`size_mask`, 13 ones}. A mask of the form 1…10…0 therefore wraps the address modulo (64 − mask)·8 KB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_addr | input | 13 | Pattern-table address |
| bank_flat | input | 64 | Eight 8-bit bank slots; slot k at bits [8k+7:8k] |
| latch_bank | input | 8 | Latch bank, in 4 KB units |
| layout | input | 3 | Window layout code 0..7 |
| latch_sel_lo | input | 1 | Lower-half slot choice in layout 5 |
| latch_sel_hi | input | 1 | Upper-half slot choice in layout 5 |
| halve | input | 1 | Halve every bank number |
| size_mask | input | 6 | Size mask on address bits [18:13] |
| chr_addr | output | 19 | Registered memory address |

## Verification
The only state in the block is the output register. A wrong routing or scaling decision therefore shows up on `chr_addr` at the first edge after the offending input combination, and nothing lingers into later cycles. A wrong slot, a wrong window size or a wrong halving shows in the upper address bits. A bad offset mask shows in the low bits. A bad fold shows as bits set under the size mask. The sweeps walk every layout, every 1 KB slice, both latch selects and both halve settings against arithmetic expectations, so each of these faults shows within one cycle of its trigger.

// File: rtl/chr_xlat_pkg.sv
package chr_xlat_pkg;
  localparam int NUM_SLOTS = 8;
  localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);
  localparam int PAT_AW = 13;
  localparam int KB_LOG2 = 10;

  typedef enum logic [2:0] {
    LY_FULL8    = 3'd0,
    LY_LATCH4   = 3'd1,
    LY_2LO_1HI  = 3'd2,
    LY_1LO_2HI  = 3'd3,
    LY_PAIR4    = 3'd4,
    LY_SELECT4  = 3'd5,
    LY_QUAD2    = 3'd6,
    LY_EIGHT1   = 3'd7
  } layout_e;

  typedef struct packed {
    logic                  from_latch;
    logic [SLOT_IDX_W-1:0] slot;
    logic [1:0]            win_log2;
  } route_t;
endpackage

// File: rtl/chr_window_sel.sv
module chr_window_sel
  import chr_xlat_pkg::*;
(
  input  logic [2:0] layout,
  input  logic [2:0] slice,
  input  logic       sel_lo,
  input  logic       sel_hi,
  output route_t     route
);
  layout_e ly;
  assign ly = layout_e'(layout);

  always_comb begin
    route = '0;
    unique case (ly)
      LY_FULL8: begin
        route.slot     = 3'd0;
        route.win_log2 = 2'd3;
      end
      LY_LATCH4: begin
        route.from_latch = 1'b1;
        route.win_log2   = 2'd2;
      end
      LY_2LO_1HI: begin
        if (!slice[2]) begin
          route.slot     = slice[1] ? 3'd2 : 3'd0;
          route.win_log2 = 2'd1;
        end else begin
          route.slot     = slice;
          route.win_log2 = 2'd0;
        end
      end
      LY_1LO_2HI: begin
        if (!slice[2]) begin
          route.slot     = {1'b1, slice[1:0]};
          route.win_log2 = 2'd0;
        end else begin
          route.slot     = slice[1] ? 3'd2 : 3'd0;
          route.win_log2 = 2'd1;
        end
      end
      LY_PAIR4: begin
        route.slot     = slice[2] ? 3'd4 : 3'd0;
        route.win_log2 = 2'd2;
      end
      LY_SELECT4: begin
        route.win_log2 = 2'd2;
        if (slice[2]) route.slot = sel_hi ? 3'd5 : 3'd4;
        else          route.slot = sel_lo ? 3'd1 : 3'd0;
      end
      LY_QUAD2: begin
        route.slot     = {slice[2:1], 1'b0};
        route.win_log2 = 2'd1;
      end
      LY_EIGHT1: begin
        route.slot     = slice;
        route.win_log2 = 2'd0;
      end
      default: route = '0;
    endcase
  end
endmodule

// File: rtl/chr_bank_scale.sv
module chr_bank_scale
  import chr_xlat_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int CHR_AW = 19
) (
  input  logic [BANK_W-1:0] bank_val,
  input  logic              from_latch,
  input  logic [1:0]        win_log2,
  input  logic              halve,
  input  logic [PAT_AW-1:0] pat_addr,
  output logic [CHR_AW-1:0] raw_addr
);
  logic [BANK_W-1:0] units;
  logic [BANK_W-1:0] units_h;
  logic [4:0]        shamt;
  logic [PAT_AW-1:0] keep;
  logic [CHR_AW-1:0] base;

  always_comb begin
    units   = from_latch ? bank_val : (bank_val >> win_log2);
    units_h = halve ? (units >> 1) : units;
    shamt   = 5'(KB_LOG2) + {3'b000, win_log2};
    keep    = {PAT_AW{1'b1}} >> (2'd3 - win_log2);
    base    = CHR_AW'(units_h) << shamt;
    raw_addr = base | CHR_AW'(pat_addr & keep);
  end
endmodule

// File: rtl/chr_size_wrap.sv
module chr_size_wrap
  import chr_xlat_pkg::*;
#(
  parameter int CHR_AW = 19,
  localparam int MASK_W = CHR_AW - PAT_AW
) (
  input  logic [CHR_AW-1:0] raw_addr,
  input  logic [MASK_W-1:0] size_mask,
  output logic [CHR_AW-1:0] wrapped
);
  assign wrapped = raw_addr & {~size_mask, {PAT_AW{1'b1}}};
endmodule

// File: rtl/chr_bank_xlat.sv
module chr_bank_xlat
  import chr_xlat_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int CHR_AW = 19,
  localparam int MASK_W = CHR_AW - PAT_AW,
  localparam int FLAT_W = NUM_SLOTS * BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAT_AW-1:0] pat_addr,
  input  logic [FLAT_W-1:0] bank_flat,
  input  logic [BANK_W-1:0] latch_bank,
  input  logic [2:0]        layout,
  input  logic              latch_sel_lo,
  input  logic              latch_sel_hi,
  input  logic              halve,
  input  logic [MASK_W-1:0] size_mask,
  output logic [CHR_AW-1:0] chr_addr
);
  logic [BANK_W-1:0] slot_arr [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slot_arr[g] = bank_flat[g*BANK_W +: BANK_W];
  end

  route_t            route;
  logic [BANK_W-1:0] chosen;
  logic [CHR_AW-1:0] raw_addr;
  logic [CHR_AW-1:0] wrapped;

  chr_window_sel u_sel (
    .layout (layout),
    .slice  (pat_addr[PAT_AW-1:KB_LOG2]),
    .sel_lo (latch_sel_lo),
    .sel_hi (latch_sel_hi),
    .route  (route)
  );

  assign chosen = route.from_latch ? latch_bank : slot_arr[route.slot];

  chr_bank_scale #(.BANK_W(BANK_W), .CHR_AW(CHR_AW)) u_scale (
    .bank_val   (chosen),
    .from_latch (route.from_latch),
    .win_log2   (route.win_log2),
    .halve      (halve),
    .pat_addr   (pat_addr),
    .raw_addr   (raw_addr)
  );

  chr_size_wrap #(.CHR_AW(CHR_AW)) u_wrap (
    .raw_addr  (raw_addr),
    .size_mask (size_mask),
    .wrapped   (wrapped)
  );

  always_ff @(posedge clk) begin
    if (rst) chr_addr <= '0;
    else     chr_addr <= wrapped;
  end
endmodule

// File: rtl/chr_xlat_chk.sv
module chr_xlat_chk #(
  parameter int CHR_AW = 19,
  localparam int MASK_W = CHR_AW - 13
) (
  input logic              clk,
  input logic              rst,
  input logic [12:0]       pat_addr,
  input logic [2:0]        layout,
  input logic [MASK_W-1:0] size_mask,
  input logic [CHR_AW-1:0] chr_addr
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (chr_addr == '0));

  p_offset_pass_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (chr_addr[9:0] == $past(pat_addr[9:0])));

  p_full_window_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(layout) == 3'd0) |-> (chr_addr[12:0] == $past(pat_addr)));

  p_latch_half_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(layout) == 3'd1) |-> (chr_addr[11:0] == $past(pat_addr[11:0])));

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((chr_addr & {$past(size_mask), 13'h0}) == '0));
endmodule

bind chr_bank_xlat chr_xlat_chk #(.CHR_AW(CHR_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pat_addr  (pat_addr),
  .layout    (layout),
  .size_mask (size_mask),
  .chr_addr  (chr_addr)
);

// File: tb/chr_bank_xlat_bench.sv
`timescale 1ns/1ps
module chr_bank_xlat_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] pat_addr = '0;
  logic [63:0] bank_flat = '0;
  logic [7:0]  latch_bank = '0;
  logic [2:0]  layout = '0;
  logic        latch_sel_lo = 1'b0;
  logic        latch_sel_hi = 1'b0;
  logic        halve = 1'b0;
  logic [5:0]  size_mask = '0;
  logic [18:0] chr_addr;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int slots [8];
  int latch_v;

  always #5 clk = ~clk;

  chr_bank_xlat u_chr_bank_xlat (
    .clk(clk), .rst(rst), .pat_addr(pat_addr), .bank_flat(bank_flat),
    .latch_bank(latch_bank), .layout(layout), .latch_sel_lo(latch_sel_lo),
    .latch_sel_hi(latch_sel_hi), .halve(halve), .size_mask(size_mask),
    .chr_addr(chr_addr)
  );

  function automatic string tag_of(int m);
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Expected address from the layout description, by KB ranges.
  function automatic int expect_addr(int m, int pa, int slo, int shi, int h, int msk);
    int kb, src, win, lat, units, raw;
    kb = pa / 1024;
    lat = 0;
    if (m == 0) begin src = slots[0]; win = 8; end
    else if (m == 1) begin src = latch_v; win = 4; lat = 1; end
    else if (m == 2) begin
      if (kb < 2) begin src = slots[0]; win = 2; end
      else if (kb < 4) begin src = slots[2]; win = 2; end
      else begin src = slots[kb]; win = 1; end
    end else if (m == 3) begin
      if (kb < 4) begin src = slots[kb + 4]; win = 1; end
      else if (kb < 6) begin src = slots[0]; win = 2; end
      else begin src = slots[2]; win = 2; end
    end else if (m == 4) begin src = (kb < 4) ? slots[0] : slots[4]; win = 4; end
    else if (m == 5) begin
      if (kb < 4) src = slo ? slots[1] : slots[0];
      else        src = shi ? slots[5] : slots[4];
      win = 4;
    end else if (m == 6) begin src = slots[(kb / 2) * 2]; win = 2; end
    else begin src = slots[kb]; win = 1; end
    units = lat ? src : src / win;
    if (h != 0) units = units / 2;
    raw = units * win * 1024 + pa % (win * 1024);
    raw = raw % (1 << 19);
    return raw % ((64 - msk) * 8192);
  endfunction

  task automatic load_slots(int seed);
    for (int k = 0; k < 8; k++) begin
      slots[k] = (seed * 37 + k * 53 + 11) % 256;
      bank_flat[k*8 +: 8] = 8'(slots[k]);
    end
    latch_v = (seed * 91 + 45) % 256;
    latch_bank = 8'(latch_v);
  endtask

  task automatic run_one(int m, int pa, int slo, int shi, int h, int msk, string tag);
    int exp;
    @(negedge clk);
    layout = 3'(m); pat_addr = 13'(pa); latch_sel_lo = 1'(slo);
    latch_sel_hi = 1'(shi); halve = 1'(h); size_mask = 6'(msk);
    exp = expect_addr(m, pa, slo, shi, h, msk);
    @(negedge clk);
    n_tests++;
    if (int'(chr_addr) != exp) begin
      n_fail++;
      $display("FAIL %s%s layout=%0d pa=%h: got %h expected %h",
               tag, (h != 0) ? "/R11" : "", m, pa, chr_addr, exp);
    end
    n_tests++;
    if (chr_addr[9:0] != 10'(pa)) begin
      n_fail++;
      $display("FAIL R2 low bits: got %h expected %h", chr_addr[9:0], pa % 1024);
    end
  endtask

  initial begin
    load_slots(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (chr_addr != '0) begin
      n_fail++;
      $display("FAIL R1 reset: got %h expected 0", chr_addr);
    end
    rst = 1'b0;

    // Layout / slice / select / halve sweep over three register sets.
    for (int s = 0; s < 3; s++) begin
      load_slots(s + 1);
      for (int m = 0; m < 8; m++)
        for (int h = 0; h < 2; h++)
          for (int sel = 0; sel < 4; sel++)
            for (int kb = 0; kb < 8; kb++)
              run_one(m, kb * 1024 + (kb * 97 + sel * 311 + s * 7) % 1024,
                      sel & 1, sel >> 1, h, 0, tag_of(m));
    end

    // R12: size folding with masks of the form 1..10..0.
    begin
      int masks [7] = '{0, 32, 48, 56, 60, 62, 63};
      load_slots(5);
      for (int i = 0; i < 7; i++)
        for (int m = 0; m < 8; m++)
          for (int kb = 0; kb < 8; kb++)
            run_one(m, kb * 1024 + 517, 1, 0, 0, masks[i], "R12");
    end

    // R1: reset mid-run clears the output.
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    n_tests++;
    if (chr_addr != '0) begin
      n_fail++;
      $display("FAIL R1 mid-run reset: got %h expected 0", chr_addr);
    end
    rst = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule